// File: doc/BRIEF.md
# Shared-Bus DMA Controller

This block is a single-channel DMA engine that moves a block of words between one I/O device and memory over a bus it shares with a CPU. Software loads a start address, a word count and a control word through a small register write port. Writing the control word with its go bit set arms the channel. The transfer then starts on the first unmasked device request. When the last word has moved, the engine gives the bus back, pulses a done strobe to the device and raises a sticky interrupt.

The engine can share the bus in three ways. In burst mode it asks for the bus once and keeps it for the whole block. In steal mode it asks for the bus for each word and gives it back after that word. In slot mode a free-running phase bit splits time into alternating DMA and CPU sub-cycles, with no request or grant at all. In slot mode an external multiplexer selects the engine's address, data and strobes whenever `dma_slot` is high.

The device side follows a valid/ready rule. `dev_req` is the valid and must stay high until the word is taken. `dev_ack` is high in the cycle in which the word moves, and a word moves only in a cycle where both are high. The engine holds off the device by keeping `dev_ack` low, either while it waits for a grant or while the slot belongs to the CPU. Memory is a single-cycle bus: a write completes at the clock edge that ends a cycle with `mem_we` high, and read data on `mem_rdata` is valid in the same cycle as `mem_re`.

Top module: `dma_share_ctrl`

## Requirements
- R1: After reset `hold_req`, `mem_we`, `mem_re`, `dev_ack`, `dev_done` and `irq` are all low.
- R2: Register writes use `cfg_addr` as follows: 0 loads the start address, 1 loads the word count and 2 loads the control word. The control word holds mode in bits [1:0], direction in bit 2, mask in bit 3 and go in bit 4. Writes to addresses 0 to 2 are ignored while a transfer is active, which runs from the first accepted request until the transfer ends. Nothing moves before the channel is armed and `dev_req` is seen.
- R3: While the control mask bit is 1, `dev_req` starts no transfer and raises no `hold_req`.
- R4: In burst and steal modes, an accepted request raises `hold_req`. No strobe is driven until `hold_ack` is high, however long the grant is withheld.
- R5: Mode 00 (burst) raises `hold_req` once for the whole block, moves one word per cycle while `dev_req` and `hold_ack` are high, and drops `hold_req` only after the last word.
- R6: Mode 01 (steal) drops `hold_req` after every word and raises it again for the next word, so a block of N words gives N grant requests.
- R7: Mode 10 (slot) never raises `hold_req` and drives a strobe only in a cycle where `dma_slot` is high. `dma_slot` toggles every cycle.
- R8: The k-th word of a block (counting from 0) uses memory address start+k. The remaining count drops by one per word.
- R9: Direction bit 0 moves device data to memory (`mem_we`, with `mem_wdata` = `dev_wdata`). Direction bit 1 moves memory to the device (`mem_re`, with `dev_rdata` = `mem_rdata`).
- R10: The clock edge after the last word raises `dev_done` for one cycle and raises `irq` in that same cycle, with `hold_req` already low.
- R11: If the count is 0 when a request arrives on an armed channel, the next cycle shows `dev_done` and `irq`, and `hold_req` is never raised.
- R12: `irq` stays high until a write to `cfg_addr` 3 with bit 0 set. While `irq` is high, control writes are ignored, so no new transfer can be armed.
- R13: Mode 11 behaves exactly like burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 start, 1 count, 2 control, 3 status clear) |
| cfg_wdata | input | RW | Register write data |
| dev_req | input | 1 | Device word request (valid) |
| dev_wdata | input | DW | Device data for device-to-memory transfers |
| dev_ack | output | 1 | Word taken this cycle (ready) |
| dev_rdata | output | DW | Memory data for memory-to-device transfers |
| dev_done | output | 1 | One-cycle end-of-block pulse |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | Bus grant from the CPU |
| dma_slot | output | 1 | High in the DMA sub-cycle of slot mode |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Sticky interrupt to the CPU |

## Verification
Two functions can fall in the same cycle: a register write to the start address, and an active burst that is holding the bus. The bench issues that write in the second cycle of a burst. It then re-arms the channel without reloading the address and checks that the second block again lands at the original address. The grant handshake is also provoked to collide with a pending request by withholding `hold_ack` for several cycles; no strobe may appear in that window. A re-arm attempt is likewise made while the interrupt is still pending, and is judged by the absence of any bus request or done pulse.

// File: rtl/dma_share_pkg.sv
package dma_share_pkg;

  typedef enum logic [1:0] {
    MODE_BURST = 2'b00,
    MODE_STEAL = 2'b01,
    MODE_SLOT  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_HREQ,
    ST_MOVE,
    ST_REL,
    ST_WAITW,
    ST_SLOT
  } st_e;

  localparam logic [1:0] REG_START = 2'd0;
  localparam logic [1:0] REG_LEN   = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  localparam int CTL_DIR  = 2;
  localparam int CTL_MASK = 3;
  localparam int CTL_GO   = 4;

  // reserved code runs as burst
  function automatic mode_e resolve_mode(input logic [1:0] code);
    return (code == 2'b11) ? MODE_BURST : mode_e'(code);
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_share_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  input  logic          active,
  input  logic          done_set,
  output logic [AW-1:0] start_addr,
  output logic [CW-1:0] xfer_len,
  output mode_e         mode,
  output logic          dir,
  output logic          mask,
  output logic          ctl_wr,
  output logic          ctl_go,
  output logic          irq
);

  logic irq_q;
  logic stat_clr;

  assign ctl_wr   = cfg_we && (cfg_addr == REG_CTRL) && !active && !irq_q;
  assign ctl_go   = cfg_wdata[CTL_GO];
  assign stat_clr = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      xfer_len   <= '0;
      mode       <= MODE_BURST;
      dir        <= 1'b0;
      mask       <= 1'b0;
    end else begin
      if (cfg_we && !active && cfg_addr == REG_START) start_addr <= cfg_wdata[AW-1:0];
      if (cfg_we && !active && cfg_addr == REG_LEN)   xfer_len   <= cfg_wdata[CW-1:0];
      if (ctl_wr) begin
        mode <= resolve_mode(cfg_wdata[1:0]);
        dir  <= cfg_wdata[CTL_DIR];
        mask <= cfg_wdata[CTL_MASK];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (done_set) irq_q <= 1'b1;
    else if (stat_clr) irq_q <= 1'b0;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !stat_clr) |=> irq_q); // R12

  AST_NO_ARM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && cfg_we && cfg_addr == REG_CTRL) |=> $stable(mode) && $stable(mask)); // R12

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] xfer_len,
  output logic [AW-1:0] cur_addr,
  output logic          last,
  output logic          empty
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
      remain   <= xfer_len;
    end else if (step) begin
      cur_addr <= cur_addr + AW'(1);
      remain   <= remain - CW'(1);
    end
  end

  assign last  = (remain == CW'(1));
  assign empty = (remain == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty); // R8

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_share_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_wr,
  input  logic  ctl_go,
  input  mode_e mode,
  input  logic  mask,
  input  logic  len_zero,
  input  logic  dev_req,
  input  logic  hold_ack,
  input  logic  slot,
  input  logic  last,
  input  logic  empty,
  output logic  hold_req,
  output logic  fire,
  output logic  start,
  output logic  active,
  output logic  done_set,
  output logic  done
);

  st_e  state, nxt;
  logic req_ok;
  logic zero_done;

  assign req_ok    = (state == ST_ARMED) && !ctl_wr && dev_req && !mask;
  assign start     = req_ok && !len_zero;
  assign zero_done = req_ok && len_zero;
  assign hold_req  = (state == ST_HREQ) || (state == ST_MOVE);
  assign fire      = dev_req && (((state == ST_MOVE) && hold_ack) ||
                                 ((state == ST_SLOT) && slot));
  assign active    = (state == ST_HREQ) || (state == ST_MOVE) || (state == ST_REL) ||
                     (state == ST_WAITW) || (state == ST_SLOT);
  assign done_set  = (fire && last) || zero_done;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (ctl_wr && ctl_go) nxt = ST_ARMED;
      ST_ARMED: begin
        if (ctl_wr)         nxt = ctl_go ? ST_ARMED : ST_IDLE;
        else if (zero_done) nxt = ST_IDLE;
        else if (start)     nxt = (mode == MODE_SLOT) ? ST_SLOT : ST_HREQ;
      end
      ST_HREQ:  if (hold_ack) nxt = ST_MOVE;
      ST_MOVE:  if (fire && (last || mode == MODE_STEAL)) nxt = ST_REL;
      ST_REL:   if (!hold_ack) nxt = empty ? ST_IDLE : ST_WAITW;
      ST_WAITW: if (dev_req) nxt = ST_HREQ;
      ST_SLOT:  if (fire && last) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= done_set;
    end
  end

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_STEAL) |=> !hold_req); // R6

  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_req) && mode == MODE_BURST) |-> done); // R5

  AST_ZERO_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> (done && !hold_req)); // R11

  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && mask && !ctl_wr) |=> !hold_req); // R3

endmodule

// File: rtl/dma_share_ctrl.sv
module dma_share_ctrl
  import dma_share_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int RW = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  input  logic          dev_req,
  input  logic [DW-1:0] dev_wdata,
  output logic          dev_ack,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_done,
  output logic          hold_req,
  input  logic          hold_ack,
  output logic          dma_slot,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);

  logic [AW-1:0] start_addr;
  logic [CW-1:0] xfer_len;
  mode_e         mode;
  logic          dir, mask, ctl_wr, ctl_go;
  logic          active, done_set, fire, start, last, empty;
  logic          slot_q;

  dma_cfg_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .active, .done_set,
    .start_addr, .xfer_len, .mode, .dir, .mask,
    .ctl_wr, .ctl_go, .irq
  );

  dma_xfer_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk, .rst_n, .load(start), .step(fire),
    .start_addr, .xfer_len,
    .cur_addr(mem_addr), .last, .empty
  );

  dma_seq u_seq (
    .clk, .rst_n, .ctl_wr, .ctl_go, .mode, .mask,
    .len_zero(xfer_len == '0),
    .dev_req, .hold_ack, .slot(slot_q), .last, .empty,
    .hold_req, .fire, .start, .active, .done_set, .done(dev_done)
  );

  // free-running sub-cycle phase for slot sharing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= 1'b0;
    else        slot_q <= ~slot_q;
  end

  assign dma_slot  = slot_q;
  assign mem_we    = fire && !dir;
  assign mem_re    = fire && dir;
  assign mem_wdata = dev_wdata;
  assign dev_rdata = mem_rdata;
  assign dev_ack   = fire;

  AST_SLOT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && !hold_ack) |-> dma_slot); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> mem_addr == $past(mem_addr) + AW'(1)); // R8

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_done |-> (irq && !hold_req)); // R10

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R9

endmodule

// File: tb/tb_dma_share_ctrl.sv
module tb_dma_share_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          dev_req = 1'b0;
  logic [DW-1:0] dev_wdata = '0;
  logic          dev_ack, dev_done, hold_req, dma_slot, mem_we, mem_re, irq;
  logic          hold_ack = 1'b0;
  logic [DW-1:0] dev_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [64];
  assign mem_rdata = mem[mem_addr[5:0]];

  int n_tests = 0;
  int n_fail  = 0;

  // results of the last run_xfer
  int n_str, n_hrise, addr_bad, slot_bad, data_bad, ack_bad;
  bit irq_at_done, hold_at_done, done_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_share_ctrl #(.AW(AW), .DW(DW), .CW(16)) dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .dev_req, .dev_wdata, .dev_ack, .dev_rdata, .dev_done,
    .hold_req, .hold_ack, .dma_slot,
    .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata, .irq
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input logic [1:0] m, input bit d, input bit mk, input bit go);
    return {11'd0, go, mk, d, m};
  endfunction

  // device and CPU model: grant follows request by half a cycle
  task automatic run_xfer(input logic [15:0] base, input logic [15:0] seed, input bit poke);
    int  idx = 0;
    int  cyc = 0;
    bit  prev_h = 1'b0;
    n_str = 0; n_hrise = 0; addr_bad = 0; slot_bad = 0; data_bad = 0; ack_bad = 0;
    done_seen = 1'b0; irq_at_done = 1'b0; hold_at_done = 1'b1;
    dev_req = 1'b1;
    while (!done_seen && cyc < 400) begin
      @(negedge clk);
      cyc++;
      cfg_we = 1'b0;
      if (poke && cyc == 2) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0030;
      end
      hold_ack  = hold_req;
      dev_wdata = seed + 16'(idx);
      #1;
      if (hold_req && !prev_h) n_hrise++;
      prev_h = hold_req;
      if (dev_done) begin
        done_seen = 1'b1; irq_at_done = irq; hold_at_done = hold_req;
      end
      if (mem_we || mem_re) begin
        n_str++;
        if (mem_addr != base + 16'(idx)) addr_bad++;
        if (!hold_ack && !dma_slot) slot_bad++;
        if (!dev_ack) ack_bad++;
        if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
        if (mem_re && dev_rdata != seed + 16'(idx)) data_bad++;
        idx++;
      end
    end
    dev_req = 1'b0; cfg_we = 1'b0;
    repeat (3) begin
      @(negedge clk);
      hold_ack = hold_req;
    end
    chk(done_seen, "R10 done pulse seen", int'(done_seen), 1);
  endtask

  task automatic t_reset;
    #1;
    chk(!hold_req && !mem_we && !mem_re && !dev_ack, "R1 bus idle", int'(hold_req), 0);
    chk(!dev_done && !irq, "R1 done/irq low", int'(irq), 0);
  endtask

  task automatic t_burst_and_ignore;
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'd5);
    wr(2'd2, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    run_xfer(16'h0004, 16'hA000, 1'b1);
    chk(n_str == 5, "R5 burst word count", n_str, 5);
    chk(n_hrise == 1, "R5 single hold", n_hrise, 1);
    chk(addr_bad == 0 && ack_bad == 0, "R8 address sequence", addr_bad, 0);
    for (int i = 0; i < 5; i++)
      chk(mem[4+i] == 16'hA000 + 16'(i), "R9 device-to-memory data", int'(mem[4+i]), 16'hA000 + i);
    chk(irq_at_done, "R10 irq with done", int'(irq_at_done), 1);
    chk(!hold_at_done, "R10 bus released at done", int'(hold_at_done), 0);
    wr(2'd3, 16'h0001);
    // re-arm without reloading the address: poked write must have been ignored
    wr(2'd2, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    run_xfer(16'h0004, 16'hB000, 1'b0);
    chk(addr_bad == 0, "R2 write during transfer ignored", addr_bad, 0);
    wr(2'd3, 16'h0001);
  endtask

  task automatic t_grant_delay;
    wr(2'd0, 16'h0018);
    wr(2'd1, 16'd2);
    wr(2'd2, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    dev_req = 1'b1; hold_ack = 1'b0;
    repeat (6) begin
      @(negedge clk);
      #1;
      chk(hold_req && !mem_we && !mem_re, "R4 no strobe before grant", int'(mem_we), 0);
    end
    run_xfer(16'h0018, 16'hD000, 1'b0);
    chk(n_str == 2, "R4 words after grant", n_str, 2);
    wr(2'd3, 16'h0001);
  endtask

  task automatic t_steal;
    for (int i = 0; i < 3; i++) mem[16+i] = 16'hC000 + 16'(i);
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'd3);
    wr(2'd2, ctl(2'b01, 1'b1, 1'b0, 1'b1));
    run_xfer(16'h0010, 16'hC000, 1'b0);
    chk(n_hrise == 3, "R6 one hold per word", n_hrise, 3);
    chk(n_str == 3, "R6 word count", n_str, 3);
    chk(data_bad == 0, "R9 memory-to-device data", data_bad, 0);
    wr(2'd3, 16'h0001);
  endtask

  task automatic t_slot;
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'd4);
    wr(2'd2, ctl(2'b10, 1'b0, 1'b0, 1'b1));
    run_xfer(16'h0020, 16'h5000, 1'b0);
    chk(n_hrise == 0, "R7 no hold in slot mode", n_hrise, 0);
    chk(slot_bad == 0, "R7 strobes only in DMA phase", slot_bad, 0);
    chk(n_str == 4 && addr_bad == 0, "R8 slot addresses", addr_bad, 0);
    chk(mem[35] == 16'h5003, "R9 slot data", int'(mem[35]), 16'h5003);
    wr(2'd3, 16'h0001);
  endtask

  task automatic t_reserved;
    wr(2'd0, 16'h0028);
    wr(2'd1, 16'd3);
    wr(2'd2, ctl(2'b11, 1'b0, 1'b0, 1'b1));
    run_xfer(16'h0028, 16'h7000, 1'b0);
    chk(n_hrise == 1 && n_str == 3, "R13 reserved runs as burst", n_hrise, 1);
    wr(2'd3, 16'h0001);
  endtask

  task automatic t_zero_and_irq;
    bit saw_hold = 1'b0;
    wr(2'd1, 16'd0);
    wr(2'd2, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    dev_req = 1'b1;
    @(negedge clk);
    #1;
    chk(dev_done && irq, "R11 immediate done", int'(dev_done), 1);
    saw_hold = hold_req;
    repeat (5) begin
      @(negedge clk);
      #1;
      saw_hold = saw_hold | hold_req;
    end
    chk(!saw_hold, "R11 no bus request", int'(saw_hold), 0);
    chk(irq, "R12 irq held", int'(irq), 1);
    // arm attempt while irq pending
    wr(2'd1, 16'd2);
    wr(2'd2, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    saw_hold = 1'b0;
    repeat (6) begin
      @(negedge clk);
      #1;
      saw_hold = saw_hold | hold_req | dev_done;
    end
    chk(!saw_hold, "R12 no arm while irq", int'(saw_hold), 0);
    dev_req = 1'b0;
    wr(2'd3, 16'h0001);
    #1;
    chk(!irq, "R12 irq cleared", int'(irq), 0);
  endtask

  task automatic t_mask;
    bit saw = 1'b0;
    wr(2'd1, 16'd2);
    wr(2'd2, ctl(2'b00, 1'b0, 1'b1, 1'b1));
    @(negedge clk);
    dev_req = 1'b1;
    repeat (6) begin
      @(negedge clk);
      #1;
      saw = saw | hold_req | mem_we | dev_done;
    end
    chk(!saw, "R3 masked request ignored", int'(saw), 0);
    dev_req = 1'b0;
    wr(2'd2, ctl(2'b00, 1'b0, 1'b0, 1'b0));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_burst_and_ignore();
    t_grant_delay();
    t_steal();
    t_slot();
    t_reserved();
    t_zero_and_irq();
    t_mask();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("[TB] FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule